// File: doc/BRIEF.md
# Sign-Demodulating Mismatch Correlator

This block measures the error of one element of an interstage converter while the converter keeps running. In the analog stage, a modulation bit sets the sign of a small error term that is added to the residue. This block takes the converter's digital output. It multiplies each valid sample by +1 or -1 using that same bit, first delayed by the converter's conversion latency. It sums the products over a session of a power-of-two number of valid samples.

When a session ends, the sum is shifted right by the session exponent, which gives the average. That average is the error estimate, and a one-cycle done strobe marks it. Over a long session, the input signal and the quantization noise average towards zero against a balanced modulation stream, and only the demodulated error term remains. The modulation bit is generated outside this block.

The session exponent is sampled with the first valid sample of each session. A new session starts from a zero sum on the very next valid sample, so sessions can run back to back.

Top module: `corr_demod_top`

## Requirements
- R1: After synchronous active-low reset, `est_o` is 0, `done_o` is 0, no samples are counted, and every stage of the modulation delay holds 0.
- R2: A sample is a signed two's-complement 10-bit code. A paired modulation bit of 1 adds the sample unchanged, and a paired bit of 0 adds its negation. The code -512 paired with 0 contributes +512.
- R3: The modulation bit paired with the sample taken at a clock edge is the `mod_i` value taken LAT=4 edges earlier. Edges during reset count as a bit of 0.
- R4: A session holds exactly 2^L valid samples, where L is `sess_log2_i` taken with the session's first valid sample (legal range 0 to 20). Changes to `sess_log2_i` later in the session have no effect on its length or its shift.
- R5: `done_o` is high for exactly one cycle, the cycle after the edge that takes a session's last sample. `est_o` carries the new estimate in that same cycle.
- R6: The estimate is floor(sum / 2^L), a signed 11-bit value in the range -512 to +512. The sum is held in a 31-bit accumulator that cannot overflow.
- R7: A cycle with `smp_vld_i` low is neither counted nor accumulated, whatever `smp_i` carries. The modulation delay still advances on such cycles.
- R8: `est_o` keeps its value between done strobes. The sample that follows a done strobe starts a new session from a zero sum, with no idle cycle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 10 | Signed converter sample |
| mod_i | input | 1 | Modulation bit, not yet delayed |
| sess_log2_i | input | 5 | Session length exponent L |
| est_o | output | 11 | Signed error estimate |
| done_o | output | 1 | One-cycle strobe for a new estimate |

## Verification
The assertions assume that the session exponent presented with a session's first sample lies between 0 and 20. They also assume that the modulation bit is a defined 0 or 1 on every cycle. The stimulus keeps the exponent within 0 to 16 and drives the modulation bit on every cycle, including reset and idle cycles.

With those inputs, the assertions check the following:
- the sample counter never reaches the latched session size;
- idle cycles leave the sum and the count untouched;
- each delay stage copies its predecessor;
- a done strobe always follows an accepted sample, and its estimate stays inside the legal range.

The bench sweeps all 1024 sample codes, every session exponent from 0 to 8, sessions interleaved with idle cycles, mid-session exponent changes, and one 65536-sample session.

// File: rtl/corr_pkg.sv
// Shared defaults for the mismatch correlator.
// Assumes: a converter with signed two's-complement output codes.
package corr_pkg;
    localparam int DEF_SMP_W    = 10;  // converter code width
    localparam int DEF_LAT      = 4;   // converter latency in clocks
    localparam int DEF_MAX_LOG2 = 20;  // largest session exponent
endpackage

// File: rtl/corr_mod_delay.sv
// Delays the modulation bit by LAT clocks so that it lines up with the
// converter output it belongs to. Assumes LAT >= 1. Shifts on every clock,
// whether or not a sample is valid.
module corr_mod_delay #(
    parameter int LAT = corr_pkg::DEF_LAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_i,
    output logic mod_o
);
    logic [LAT-1:0] st;

    // first stage captures the raw bit
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= 1'b0;
        else        st[0] <= mod_i;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        // each later stage copies the one before it
        always_ff @(posedge clk) begin
            if (!rst_n) st[i] <= 1'b0;
            else        st[i] <= st[i-1];
        end

        p_stage_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (st[i] == $past(st[i-1])));
    end

    assign mod_o = st[LAT-1];

    p_first_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st[0] == $past(mod_i)));
endmodule

// File: rtl/corr_session_ctl.sv
// Counts valid samples in a session and flags the last one. The session
// exponent is captured with the first sample, and later changes are ignored.
// Assumes an exponent of at most MAX_LOG2.
module corr_session_ctl #(
    parameter int MAX_LOG2 = corr_pkg::DEF_MAX_LOG2,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W   = MAX_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [LOG_W-1:0] log2_i,
    output logic             last_o,
    output logic [LOG_W-1:0] shift_o
);
    logic [CNT_W-1:0] cnt;
    logic [LOG_W-1:0] cur_log2;
    logic [LOG_W-1:0] eff_log2;
    logic [CNT_W-1:0] sess_size;

    // the exponent comes from the port on the first sample, else from the latch
    always_comb begin
        eff_log2  = (cnt == '0) ? log2_i : cur_log2;
        sess_size = CNT_W'(1) << eff_log2;
        last_o    = vld_i && ((cnt + CNT_W'(1)) == sess_size);
        shift_o   = eff_log2;
    end

    // count valid samples and wrap at the end of the session
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_log2 <= '0;
        end else if (vld_i) begin
            if (cnt == '0) cur_log2 <= log2_i;
            cnt <= last_o ? '0 : cnt + CNT_W'(1);
        end
    end

    p_sess_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && cnt == '0) |-> (log2_i <= LOG_W'(MAX_LOG2)));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt < (CNT_W'(1) << cur_log2)));

    p_idle_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(cnt));
endmodule

// File: rtl/corr_accum.sv
// Adds signed products of sample and sign. On the session's last sample it
// writes the shifted sum to the estimate, raises done for one cycle and
// clears the sum. Assumes the accumulator is wide enough for 2^MAX_LOG2
// full-scale samples.
module corr_accum #(
    parameter int SMP_W    = corr_pkg::DEF_SMP_W,
    parameter int MAX_LOG2 = corr_pkg::DEF_MAX_LOG2,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int ACC_W   = SMP_W + MAX_LOG2 + 1,
    localparam int EST_W   = SMP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             sign_i,
    input  logic             last_i,
    input  logic [LOG_W-1:0] shift_i,
    output logic [EST_W-1:0] est_o,
    output logic             done_o
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] sum_next;
    logic signed [ACC_W-1:0] avg;

    // sign-extend the sample and apply the demodulation sign
    always_comb begin
        ext      = {{(ACC_W-SMP_W){smp_i[SMP_W-1]}}, smp_i};
        prod     = sign_i ? ext : -ext;
        sum_next = acc + prod;
        avg      = sum_next >>> shift_i;
    end

    // accumulate, and close the session on its last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            est_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (vld_i) begin
                if (last_i) begin
                    acc    <= '0;
                    est_o  <= avg[EST_W-1:0];
                    done_o <= 1'b1;
                end else begin
                    acc <= sum_next;
                end
            end
        end
    end

    p_done_follows_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(vld_i));

    p_est_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($signed(est_o) <= $signed(EST_W'(1) << (SMP_W-1))
                 && $signed(est_o) >= -$signed(EST_W'(1) << (SMP_W-1))));

    p_idle_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(acc));

    p_est_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done_o) |-> $stable(est_o));
endmodule

// File: rtl/corr_demod_top.sv
// Top of the correlator. It delays the modulation bit, times each session,
// and accumulates signed samples into a per-session average.
// Assumes a power-of-two session length, given as an exponent.
module corr_demod_top #(
    parameter int SMP_W    = corr_pkg::DEF_SMP_W,
    parameter int LAT      = corr_pkg::DEF_LAT,
    parameter int MAX_LOG2 = corr_pkg::DEF_MAX_LOG2,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int EST_W   = SMP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             mod_i,
    input  logic [LOG_W-1:0] sess_log2_i,
    output logic [EST_W-1:0] est_o,
    output logic             done_o
);
    logic             mod_dly;
    logic             last;
    logic [LOG_W-1:0] shift;

    corr_mod_delay #(.LAT(LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .mod_i (mod_i),
        .mod_o (mod_dly)
    );

    corr_session_ctl #(.MAX_LOG2(MAX_LOG2)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (smp_vld_i),
        .log2_i  (sess_log2_i),
        .last_o  (last),
        .shift_o (shift)
    );

    corr_accum #(.SMP_W(SMP_W), .MAX_LOG2(MAX_LOG2)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (smp_vld_i),
        .smp_i   (smp_i),
        .sign_i  (mod_dly),
        .last_i  (last),
        .shift_i (shift),
        .est_o   (est_o),
        .done_o  (done_o)
    );
endmodule

// File: tb/sim_corr_demod_top.sv
module sim_corr_demod_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int WDOG       = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [9:0]  smp = '0;
    logic        mod = 1'b0;
    logic [4:0]  sl = '0;
    logic [10:0] est;
    logic        done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic finished = 1'b0;

    // bench model state
    logic    hist [LAT];
    longint  msum = 0;
    longint  mcnt = 0;
    int      mlog = 0;
    longint  mest = 0;
    int unsigned rng = 32'h1234_5678;

    corr_demod_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_i(smp),
        .mod_i(mod), .sess_log2_i(sl), .est_o(est), .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned nextr(int unsigned x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // drive one cycle at a falling edge, update the model, check at the next falling edge
    task automatic step(input logic v, input int s, input logic m, input int l, input string req);
        longint prod;
        logic   exp_done;
        logic   pm;
        vld = v; smp = 10'(s); mod = m; sl = 5'(l);
        pm = hist[LAT-1];
        prod = pm ? longint'(s) : -longint'(s);
        exp_done = 1'b0;
        if (v) begin
            if (mcnt == 0) mlog = l;
            msum += prod;
            mcnt++;
            if (mcnt == (longint'(1) << mlog)) begin
                mest = msum >>> mlog;
                exp_done = 1'b1;
                msum = 0;
                mcnt = 0;
            end
        end
        for (int i = LAT-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = m;
        @(negedge clk);
        check({req, " R5 done"}, longint'(done), longint'(exp_done));
        check(exp_done ? {req, " R6 estimate"} : {req, " R8 hold"},
              longint'($signed(est)), mest);
    endtask

    function automatic int sval(int unsigned r);
        return int'(r % 1024) - 512;
    endfunction

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", WDOG);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge clk) cycles++;

    initial begin : main
        for (int i = 0; i < LAT; i++) hist[i] = 1'b0;
        // R1: reset state, with the modulation bit held at 0 during reset
        rst_n = 1'b0; mod = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done at reset", longint'(done), 0);
        check("R1 est at reset", longint'($signed(est)), 0);
        rst_n = 1'b1;

        // R2 R3: all codes, L=0, varied modulation; the first LAT samples pair with the cleared delay
        for (int s = 0; s < 1024; s++) begin
            rng = nextr(rng);
            step(1'b1, s - 512, rng[7], 0, "R2/R3 sweep");
        end
        // R2 edge: -512 paired with bit 0 gives +512
        for (int i = 0; i < LAT; i++) step(1'b0, 0, 1'b0, 0, "R2 prime");
        step(1'b1, -512, 1'b0, 0, "R2 neg full scale");
        check("R2 -512 negated", longint'($signed(est)), 512);

        // R7: idle cycles with large samples between valid ones, L=3
        for (int k = 0; k < 48; k++) begin
            rng = nextr(rng);
            if (k % 3 == 1) step(1'b0, 511, rng[3], 3, "R7 idle");
            else            step(1'b1, sval(rng), rng[3], 3, "R7 valid");
        end

        // R4: exponent changes inside a session are ignored (starts at L=2)
        for (int k = 0; k < 12; k++) begin
            rng = nextr(rng);
            step(1'b1, sval(rng), rng[5], (k % 4 == 0) ? 2 : (k % 5), "R4 latch");
        end

        // R4 R6 R8: every exponent 0..8, two back-to-back sessions each
        for (int l = 0; l <= 8; l++) begin
            for (int n = 0; n < 2 * (1 << l); n++) begin
                rng = nextr(rng);
                step(1'b1, sval(rng), rng[9], l, "R4/R6 sweep");
            end
        end

        // R6: one long session (2^16) with an offset and a large signal
        for (int n = 0; n < 65536; n++) begin
            rng = nextr(rng);
            step(1'b1, (n % 200) * 5 - 500 + (rng[11] ? 3 : 0), rng[11], 16, "R6 long");
        end
        step(1'b0, 0, 1'b0, 0, "R8 tail");

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule